// File: doc/BRIEF.md
# Always-On Secondary Watchdog

This block is a second, independent watchdog that runs from the fast clock and keeps counting even when the main timer watchdogs are stopped. Software restarts it by writing a feed strobe. If the count reaches the fixed timeout, the block sends a reset-request pulse of programmable length toward external reset circuitry. It also sets a sticky flag so that firmware can later tell that the reset came from this watchdog. Halfway to the timeout it raises a warning interrupt, which gives software one last chance to feed before the reset.

A hardware auto-feed mode keeps the counter at zero with no software effort. A halt bit stops the watchdog. The control register accepts writes only while a separate key register holds the unlock value. The interrupt has raw, enable and status bits and a write-one clear, and the interrupt registers are not behind the lock. After a pulse ends, the counter starts again from zero.

Top module: `swd_top`

## Requirements
- R1: After reset, rst_req and irq are 0, and a read of the control register (address 0) shows reset flag 0, auto-feed 0, halt 0 and the width field at DEF_WIDTH.
- R2: A control write (address 0) takes effect only while the key register (address 1) holds KEY. Otherwise the whole write is ignored, including the feed strobe (bit 12) and the flag-clear strobe (bit 13). Address 1 reads 1 in bit 0 while the key matches.
- R3: While running and not fed, rst_req rises after the TIMEOUT-th clock edge following the edge at which the counter last restarted.
- R4: rst_req stays high for exactly W cycles, where W is the width field (control bits 11:2). A width of 0 gives a 1-cycle pulse.
- R5: The counter is held at zero during the pulse and restarts after it, so consecutive unfed pulses are separated by exactly TIMEOUT low cycles.
- R6: Each timeout sets the reset flag (control read bit 31). The flag stays set until a control write with bit 13 set clears it. A timeout in the same cycle as the clear wins.
- R7: A control write with bit 12 set restarts the count from zero, so feeding more often than every TIMEOUT cycles prevents any pulse.
- R8: While auto-feed (control bit 0) is 1, no timeout and no warning occur.
- R9: While halt (control bit 1) is 1, the counter is cleared and no timeout occurs.
- R10: When the count reaches TIMEOUT/2, the raw interrupt (address 2 bit 0) sets. Address 2 bit 1 is the enable (written through bit 1), bit 2 is the status (raw AND enable), and irq equals the status.
- R11: Writing 1 to bit 0 of address 3 clears the raw interrupt. A warning in the same cycle wins.
- R12: The width field is written through control bits 11:2 and reads back in the same position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for writes and reads |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| rst_req | output | 1 | Reset-request pulse to external circuitry |
| irq | output | 1 | Warning interrupt (status) |

## Verification
The bench builds the block with TIMEOUT of 40 and DEF_WIDTH of 5. With these values a full timeout, the warning at cycle 20, and back-to-back unfed pulses each take only tens of cycles. This lets thousands of random register writes run across many timeout, clear and lock episodes. A width of 0 and widths up to 7 are driven so that the clamp to one cycle and the restart after the pulse are both reached.

// File: rtl/swd_pkg.sv
package swd_pkg;
  localparam int WIDTH_W  = 10;
  localparam int CTL_AUTO = 0;
  localparam int CTL_HALT = 1;
  localparam int CTL_WLO  = 2;
  localparam int CTL_FEED = 12;
  localparam int CTL_FCLR = 13;
  localparam int CTL_FLAG = 31;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_KEY  = 2'd1,
    A_IRQ  = 2'd2,
    A_ICLR = 2'd3
  } swd_addr_e;

  typedef struct packed {
    logic               auto_feed;
    logic               halt;
    logic [WIDTH_W-1:0] width;
  } swd_cfg_t;

  // Pulse length in cycles; a zero field still yields one cycle.
  function automatic logic [WIDTH_W-1:0] pulse_len(input logic [WIDTH_W-1:0] w);
    return (w == '0) ? WIDTH_W'(1) : w;
  endfunction

  // Count value at which the early warning fires.
  function automatic int warn_point(input int timeout);
    return timeout / 2;
  endfunction
endpackage

// File: rtl/swd_sticky.sv
module swd_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end
endmodule

// File: rtl/swd_regs.sv
module swd_regs #(
  parameter logic [31:0] KEY = 32'h50D83AA1,
  parameter int DEF_WIDTH = 300
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [1:0]            addr,
  input  logic [31:0]           wdata,
  input  logic                  flag,
  input  logic                  raw,
  output swd_pkg::swd_cfg_t     cfg,
  output logic                  irq_en,
  output logic                  unlocked,
  output logic                  ctrl_wr,
  output logic                  ctrl_blocked,
  output logic                  feed_evt,
  output logic                  flag_clr_evt,
  output logic                  irq_clr_evt,
  output logic [31:0]           rdata
);
  import swd_pkg::*;

  logic [31:0] key_q;
  logic        sel_ctrl;

  assign unlocked     = (key_q == KEY);
  assign sel_ctrl     = wr_en && (addr == A_CTRL);
  assign ctrl_wr      = sel_ctrl && unlocked;
  assign ctrl_blocked = sel_ctrl && !unlocked;
  assign feed_evt     = ctrl_wr && wdata[CTL_FEED];
  assign flag_clr_evt = ctrl_wr && wdata[CTL_FCLR];
  assign irq_clr_evt  = wr_en && (addr == A_ICLR) && wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg.auto_feed <= 1'b0;
      cfg.halt      <= 1'b0;
      cfg.width     <= WIDTH_W'(DEF_WIDTH);
    end else if (ctrl_wr) begin
      cfg.auto_feed <= wdata[CTL_AUTO];
      cfg.halt      <= wdata[CTL_HALT];
      cfg.width     <= wdata[CTL_WLO +: WIDTH_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          key_q <= '0;
    else if (wr_en && addr == A_KEY)     key_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          irq_en <= 1'b0;
    else if (wr_en && addr == A_IRQ)     irq_en <= wdata[1];
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_CTRL: begin
        rdata[CTL_FLAG]             = flag;
        rdata[CTL_WLO +: WIDTH_W]   = cfg.width;
        rdata[CTL_HALT]             = cfg.halt;
        rdata[CTL_AUTO]             = cfg.auto_feed;
      end
      A_KEY:  rdata[0] = unlocked;
      A_IRQ:  rdata[2:0] = {raw & irq_en, irq_en, raw};
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/swd_timer.sv
module swd_timer #(
  parameter int TIMEOUT = 4096,
  localparam int CW = $clog2(TIMEOUT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          halt,
  input  logic          feed,
  input  logic          pulsing,
  output logic [CW-1:0] cnt,
  output logic          timeout_evt,
  output logic          warn_evt
);
  localparam logic [CW-1:0] LAST    = CW'(TIMEOUT - 1);
  localparam logic [CW-1:0] WARN_M1 = CW'(swd_pkg::warn_point(TIMEOUT) - 1);

  logic run;
  assign run         = !halt && !pulsing && !feed;
  assign timeout_evt = run && (cnt == LAST);
  assign warn_evt    = run && (cnt == WARN_M1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (!run || timeout_evt) cnt <= '0;
    else                          cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/swd_pulse.sv
module swd_pulse #(
  parameter int WW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [WW-1:0] width,
  output logic          active
);
  logic [WW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            left <= '0;
    else if (start)        left <= swd_pkg::pulse_len(width);
    else if (left != '0)   left <= left - WW'(1);
  end

  assign active = (left != '0);
endmodule

// File: rtl/swd_top.sv
module swd_top #(
  parameter int          TIMEOUT   = 4096,
  parameter int          DEF_WIDTH = 300,
  parameter logic [31:0] KEY       = 32'h50D83AA1,
  localparam int CW = $clog2(TIMEOUT)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        rst_req,
  output logic        irq
);
  import swd_pkg::*;

  swd_cfg_t      cfg;
  logic          irq_en, unlocked, ctrl_wr, ctrl_blocked;
  logic          feed_evt, flag_clr_evt, irq_clr_evt;
  logic          any_feed, timeout_evt, warn_evt;
  logic          flag_q, raw_q;
  logic [CW-1:0] cnt;

  swd_regs #(.KEY(KEY), .DEF_WIDTH(DEF_WIDTH)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .flag(flag_q), .raw(raw_q), .cfg(cfg), .irq_en(irq_en),
    .unlocked(unlocked), .ctrl_wr(ctrl_wr), .ctrl_blocked(ctrl_blocked),
    .feed_evt(feed_evt), .flag_clr_evt(flag_clr_evt),
    .irq_clr_evt(irq_clr_evt), .rdata(rdata)
  );

  assign any_feed = feed_evt || cfg.auto_feed;

  swd_timer #(.TIMEOUT(TIMEOUT)) u_timer (
    .clk(clk), .rst_n(rst_n), .halt(cfg.halt), .feed(any_feed),
    .pulsing(rst_req), .cnt(cnt), .timeout_evt(timeout_evt),
    .warn_evt(warn_evt)
  );

  swd_pulse #(.WW(WIDTH_W)) u_pulse (
    .clk(clk), .rst_n(rst_n), .start(timeout_evt), .width(cfg.width),
    .active(rst_req)
  );

  // Sticky bits: index 0 is the reset flag, index 1 the raw interrupt.
  logic [1:0] st_set, st_clr, st_q;
  assign st_set = {warn_evt, timeout_evt};
  assign st_clr = {irq_clr_evt, flag_clr_evt};

  for (genvar i = 0; i < 2; i++) begin : g_sticky
    swd_sticky u_st (
      .clk(clk), .rst_n(rst_n), .set(st_set[i]), .clr(st_clr[i]), .q(st_q[i])
    );
  end

  assign flag_q = st_q[0];
  assign raw_q  = st_q[1];
  assign irq    = raw_q && irq_en;
endmodule

// File: rtl/swd_checker.sv
module swd_checker #(
  parameter int WW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rst_req,
  input logic          timeout_evt,
  input logic          warn_evt,
  input logic          auto_feed,
  input logic          halt,
  input logic          flag_q,
  input logic          flag_clr_evt,
  input logic          raw_q,
  input logic          irq_clr_evt,
  input logic          ctrl_blocked,
  input logic [WW+1:0] cfg_bits
);
  assert_locked_ctrl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_blocked |=> $stable(cfg_bits));

  assert_timeout_starts_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |=> rst_req);

  assert_pulse_from_timeout_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> $past(timeout_evt));

  assert_no_timeout_in_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> !timeout_evt);

  assert_flag_on_timeout_R6: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |=> flag_q);

  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr_evt) |=> flag_q);

  assert_autofeed_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    auto_feed |-> (!timeout_evt && !warn_evt));

  assert_halt_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> !timeout_evt);

  assert_warn_sets_raw_R10: assert property (@(posedge clk) disable iff (!rst_n)
    warn_evt |=> raw_q);

  assert_irq_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr_evt && !warn_evt) |=> !raw_q);
endmodule

bind swd_top swd_checker #(.WW(swd_pkg::WIDTH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .timeout_evt(timeout_evt),
  .warn_evt(warn_evt), .auto_feed(cfg.auto_feed), .halt(cfg.halt),
  .flag_q(flag_q), .flag_clr_evt(flag_clr_evt), .raw_q(raw_q),
  .irq_clr_evt(irq_clr_evt), .ctrl_blocked(ctrl_blocked), .cfg_bits(cfg)
);

// File: tb/tb_swd_top.sv
module tb_swd_top;
  localparam int          T   = 40;
  localparam int          DW  = 5;
  localparam logic [31:0] KEY = 32'h50D83AA1;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  addr;
  logic [31:0] wdata, rdata;
  logic        rst_req, irq;

  always #4 clk = ~clk;

  swd_top #(.TIMEOUT(T), .DEF_WIDTH(DW), .KEY(KEY)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rst_req(rst_req), .irq(irq)
  );

  int total = 0;
  int fails = 0;

  // Reference state, advanced from the requirements at each rising edge.
  int          mc, mp;
  logic        mflag, mraw, men, mauto, mhalt;
  logic [9:0]  mw;
  logic [31:0] mkey;

  always @(posedge clk) begin
    if (!rst_n) begin
      mc = 0; mp = 0; mflag = 0; mraw = 0; men = 0;
      mauto = 0; mhalt = 0; mw = 10'(DW); mkey = 0;
    end else begin
      logic okw, fd, fc, run, tmo, wrn;
      okw = wr_en && addr == 2'd0 && mkey == KEY;
      fd  = (okw && wdata[12]) || mauto;
      fc  = okw && wdata[13];
      run = !mhalt && mp == 0 && !fd;
      tmo = run && mc == T - 1;
      wrn = run && mc == T / 2 - 1;
      mc  = (!run || tmo) ? 0 : mc + 1;
      if (tmo) mp = (mw == 0) ? 1 : int'(mw);
      else if (mp > 0) mp = mp - 1;
      if (tmo) mflag = 1; else if (fc) mflag = 0;
      if (wrn) mraw = 1; else if (wr_en && addr == 2'd3 && wdata[0]) mraw = 0;
      if (okw) begin mauto = wdata[0]; mhalt = wdata[1]; mw = wdata[11:2]; end
      if (wr_en && addr == 2'd1) mkey = wdata;
      if (wr_en && addr == 2'd2) men = wdata[1];
    end
  end

  function automatic logic [31:0] exp_rd(input logic [1:0] a);
    logic [31:0] r = '0;
    case (a)
      2'd0: begin r[31] = mflag; r[11:2] = mw; r[1] = mhalt; r[0] = mauto; end
      2'd1: r[0] = (mkey == KEY);
      2'd2: r[2:0] = {mraw & men, men, mraw};
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic logic [31:0] ctrlw(input logic au, input logic hl,
      input int w, input logic fd, input logic fc);
    logic [31:0] d = '0;
    d[0] = au; d[1] = hl; d[11:2] = 10'(w); d[12] = fd; d[13] = fc;
    return d;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [1:0] a, input logic [31:0] d);
    wr_en = we; addr = a; wdata = d;
    @(posedge clk); #2;
    chk("R4 rst_req vs model", {31'b0, rst_req}, {31'b0, mp != 0});
    chk("R10 irq vs model", {31'b0, irq}, {31'b0, mraw & men});
    chk("R12 readback vs model", rdata, exp_rd(a));
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    total++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    int k, seen;
    logic [31:0] d;
    rst_n = 0; wr_en = 0; addr = 0; wdata = 0;
    d = $urandom(32'h5eed);
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    // R1 reset state
    chk("R1 rst_req after reset", {31'b0, rst_req}, 0);
    chk("R1 irq after reset", {31'b0, irq}, 0);
    chk("R1 ctrl read after reset", rdata, 32'(DW) << 2);

    // R2 locked control write ignored
    step(1, 2'd0, ctrlw(0, 1, 9, 0, 0));
    step(0, 2'd0, 0);
    chk("R2 locked write ignored", rdata, 32'(DW) << 2);
    step(1, 2'd1, KEY);
    step(0, 2'd1, 0);
    chk("R2 key match reads 1", rdata, 1);
    step(1, 2'd2, 32'h2);

    // R7 feed, R3 timeout distance
    step(1, 2'd0, ctrlw(0, 0, DW, 1, 0));
    k = 0;
    do begin step(0, 2'd0, 0); k++; end while (!rst_req && k < 500);
    chk("R3 timeout distance", k, T);
    k = 0;
    while (rst_req && k < 500) begin step(0, 2'd0, 0); k++; end
    chk("R4 pulse width", k, DW);
    chk("R6 flag set after timeout", rdata[31], 1);
    k = 0;
    while (!rst_req && k < 500) begin step(0, 2'd0, 0); k++; end
    chk("R5 gap between unfed pulses", k, T);
    while (rst_req) step(0, 2'd0, 0);
    step(1, 2'd0, ctrlw(0, 0, DW, 1, 1));
    chk("R6 flag cleared", rdata[31], 0);

    // R10 warning point, R11 clear
    step(1, 2'd0, ctrlw(0, 0, DW, 1, 0));
    step(1, 2'd3, 1);
    k = 1;
    step(0, 2'd2, 0);
    k++;
    chk("R11 raw cleared", rdata[0], 0);
    while (!rdata[0] && k < 500) begin step(0, 2'd2, 0); k++; end
    chk("R10 warning at half timeout", k, T / 2);
    chk("R10 status bit", rdata[2], 1);
    chk("R10 irq pin", {31'b0, irq}, 1);

    // R4 width zero gives one cycle
    step(1, 2'd0, ctrlw(0, 0, 0, 1, 0));
    k = 0;
    while (!rst_req && k < 500) begin step(0, 2'd0, 0); k++; end
    k = 0;
    while (rst_req && k < 500) begin step(0, 2'd0, 0); k++; end
    chk("R4 width zero pulse", k, 1);

    // R7 periodic feeding prevents reset
    seen = 0;
    for (int i = 0; i < 5; i++) begin
      step(1, 2'd0, ctrlw(0, 0, DW, 1, 0));
      for (int j = 0; j < T - 3; j++) begin step(0, 2'd0, 0); if (rst_req) seen++; end
    end
    chk("R7 no pulse while fed", seen, 0);

    // R8 auto-feed
    step(1, 2'd0, ctrlw(1, 0, DW, 0, 0));
    step(1, 2'd3, 1);
    seen = 0;
    for (int j = 0; j < 3 * T; j++) begin step(0, 2'd2, 0); if (rst_req || rdata[0]) seen++; end
    chk("R8 auto-feed quiet", seen, 0);

    // R9 halt
    step(1, 2'd0, ctrlw(0, 1, DW, 0, 0));
    seen = 0;
    for (int j = 0; j < 3 * T; j++) begin step(0, 2'd0, 0); if (rst_req) seen++; end
    chk("R9 halt quiet", seen, 0);

    // R2 feed ignored while locked
    step(1, 2'd0, ctrlw(0, 0, DW, 1, 0));
    step(1, 2'd1, 0);
    k = 1;
    while (!rst_req && k < 500) begin step(1, 2'd0, ctrlw(0, 0, DW, 1, 0)); k++; end
    chk("R2 locked feed ignored", k, T);
    step(1, 2'd1, KEY);

    // Random phase against the reference state
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] a;
      a = 2'($urandom % 4);
      if ($urandom % 6 == 0) begin
        d = $urandom;
        if (a == 2'd0) begin
          d[0] = ($urandom % 8 == 0);
          d[1] = ($urandom % 8 == 0);
          d[11:2] = 10'($urandom % 8);
          d[12] = ($urandom % 4 == 0);
        end
        if (a == 2'd1 && $urandom % 4 != 0) d = KEY;
        step(1, a, d);
      end else begin
        step(0, a, 0);
      end
    end
    finish_run();
  end
endmodule